// File: doc/BRIEF.md
# Packet Memory Data Port with Auto-Increment

This block gives a host processor word-wide access to an internal packet memory. The memory is split into fixed 2 KB pages, one per packet. The host picks a page by writing a packet-number register. It then loads a pointer register that holds a byte offset and three mode flags: auto-advance, read direction and receive-side selection. After that, each read or write of the data port moves 16 or 32 bits at the pointer. When auto-advance is set, the pointer steps by the access width after every accepted access.

Host writes pass through a small write buffer, which drains one halfword per cycle into memory. While that buffer holds data, a busy flag stays high and any attempt to reload the pointer is ignored. When receive-side selection is on, the page comes from the head of an external receive queue instead of the packet-number register. Each stored packet opens with a status halfword followed by a byte-count halfword. Only the low 11 bits of that count are returned on reads.

Top module: `pkt_data_port`

## Requirements
- R1: While reset is asserted and on release, the pointer readback is zero, the packet number is zero, the busy flag is low and no read data is flagged valid.
- R2: A pointer-register write loads byte offset bits 10:0, the receive-select flag in bit 12, the read-direction flag in bit 13 and the auto-advance flag in bit 14. Bits 11 and 15 read back as zero. A pointer write that arrives while the busy flag is high is discarded.
- R3: With the receive-select flag set, accesses address the page named by the receive-queue head input. With it clear, they address the page in the packet-number register.
- R4: Byte offset bit 0 is ignored. A 16-bit write (data_wide_i low) stores data bits 15:0 at the addressed halfword. A 16-bit read returns that halfword in bits 15:0, with bits 31:16 zero, and the read-valid flag is high in the cycle after the request.
- R5: A 32-bit access moves the halfword at the offset in bits 15:0 and the next halfword in bits 31:16. A 32-bit read at offset 0 therefore returns the status in the low half and the byte count in the high half.
- R6: With auto-advance set, each accepted access adds 2 (16-bit) or 4 (32-bit) to the offset, modulo 2048. With auto-advance clear, the offset does not change.
- R7: A data write while the read-direction flag is set, or a data read while it is clear, is ignored. Memory, the pointer and the busy flag are unchanged, and no read-valid is produced.
- R8: Any returned halfword located at byte offset 2 of a page (the byte-count word) has bits 15:11 forced to zero.
- R9: Each accepted write raises the busy flag on the following cycle. The buffer holds up to 4 halfwords and retires one per cycle, and the busy flag drops once it is empty.
- R10: The half of a 32-bit access that falls at or beyond byte offset 2048 is dropped. A write to it changes no memory, and a read of it returns zero. The pointer wraps within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pnr_we_i | input | 1 | Packet-number register write strobe |
| pnr_wdata_i | input | PKT_W | Packet number to load |
| rx_head_i | input | PKT_W | Packet number at the head of the receive queue |
| ptr_we_i | input | 1 | Pointer register write strobe |
| ptr_wdata_i | input | 16 | Pointer value (offset and mode flags) |
| data_wr_i | input | 1 | Data port write strobe |
| data_rd_i | input | 1 | Data port read strobe |
| data_wide_i | input | 1 | Access width: 0 is 16-bit, 1 is 32-bit |
| data_wdata_i | input | 32 | Write data |
| data_rdata_o | output | 32 | Read data, registered |
| data_rvalid_o | output | 1 | Read data valid, one cycle after an accepted read |
| ptr_o | output | 16 | Pointer register readback |
| ptr_busy_o | output | 1 | Write buffer not empty |

## Verification
The checker assumes the host never issues more write halfwords than the 4-entry buffer can take, and never strobes the pointer and the data port in the same cycle. The increment and no-increment properties rely on that second assumption. The stimulus does at most two back-to-back 32-bit writes, which peaks at three buffered halfwords. It waits for the busy flag to drop before any later write burst, and it drives each strobe alone in its own cycle. Reads only follow a pointer reload, and a reload cannot happen while the buffer is busy, so reads never see stale memory.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int OFF_W     = 11;   // byte offset inside a 2 KB page
  localparam int HALF_W    = 16;
  localparam int CNT_BITS  = 11;   // significant bits of the byte-count word
  localparam int PTR_RCV   = 12;
  localparam int PTR_RD    = 13;
  localparam int PTR_AINC  = 14;

  // byte-count halfword keeps only its low CNT_BITS bits on readback
  function automatic logic [HALF_W-1:0] view_half(input logic [HALF_W-1:0] d,
                                                  input logic is_cnt);
    view_half = is_cnt ? {{(HALF_W-CNT_BITS){1'b0}}, d[CNT_BITS-1:0]} : d;
  endfunction
endpackage

// File: rtl/pdp_ptr.sv
module pdp_ptr
  import pdp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [15:0] load_val_i,
  input  logic        step_i,
  input  logic        wide_i,
  output logic [15:0] ptr_o
);
  logic [OFF_W-1:0] off_q;
  logic             ainc_q, rd_q, rcv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= '0;
      ainc_q <= 1'b0;
      rd_q   <= 1'b0;
      rcv_q  <= 1'b0;
    end else if (load_i) begin
      off_q  <= load_val_i[OFF_W-1:0];
      ainc_q <= load_val_i[PTR_AINC];
      rd_q   <= load_val_i[PTR_RD];
      rcv_q  <= load_val_i[PTR_RCV];
    end else if (step_i && ainc_q) begin
      off_q <= off_q + (wide_i ? OFF_W'(4) : OFF_W'(2));
    end
  end

  always_comb begin
    ptr_o            = '0;
    ptr_o[OFF_W-1:0] = off_q;
    ptr_o[PTR_AINC]  = ainc_q;
    ptr_o[PTR_RD]    = rd_q;
    ptr_o[PTR_RCV]   = rcv_q;
  end
endmodule

// File: rtl/pdp_wbuf.sv
module pdp_wbuf #(
  parameter int DEPTH = 4,
  parameter int EW    = 26,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_lo_i,
  input  logic [EW-1:0] lo_i,
  input  logic          push_hi_i,
  input  logic [EW-1:0] hi_i,
  output logic          pop_o,
  output logic [EW-1:0] head_o,
  output logic [CW-1:0] cnt_o
);
  logic [EW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] n_push;

  assign pop_o  = (cnt_q != '0);
  assign head_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;
  assign n_push = CW'(push_lo_i) + CW'(push_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (pop_o) rp_q <= rp_q + 1'b1;
      wp_q  <= wp_q + PW'(n_push);
      cnt_q <= cnt_q + n_push - CW'(pop_o);
    end
  end

  // storage carries no reset; entries are written before they are read
  always_ff @(posedge clk_i) begin
    if (push_lo_i && push_hi_i) begin
      mem_q[wp_q]        <= lo_i;
      mem_q[wp_q + 1'b1] <= hi_i;
    end else if (push_lo_i) begin
      mem_q[wp_q] <= lo_i;
    end else if (push_hi_i) begin
      mem_q[wp_q] <= hi_i;
    end
  end
endmodule

// File: rtl/pdp_ram.sv
module pdp_ram #(
  parameter int AW = 11,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
  import pdp_pkg::*;
#(
  parameter int NUM_PKTS   = 2,
  parameter int FIFO_DEPTH = 4,
  localparam int PKT_W  = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1,
  localparam int WIDX_W = OFF_W - 1,
  localparam int AW     = PKT_W + WIDX_W,
  localparam int EW     = AW + HALF_W,
  localparam int CW     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pnr_we_i,
  input  logic [PKT_W-1:0] pnr_wdata_i,
  input  logic [PKT_W-1:0] rx_head_i,
  input  logic             ptr_we_i,
  input  logic [15:0]      ptr_wdata_i,
  input  logic             data_wr_i,
  input  logic             data_rd_i,
  input  logic             data_wide_i,
  input  logic [31:0]      data_wdata_i,
  output logic [31:0]      data_rdata_o,
  output logic             data_rvalid_o,
  output logic [15:0]      ptr_o,
  output logic             ptr_busy_o
);
  logic [PKT_W-1:0]  pnr_q, pkt_sel;
  logic [WIDX_W-1:0] widx, widx_hi;
  logic              hi_in, wr_ok, rd_ok, ptr_load;
  logic              buf_pop;
  logic [EW-1:0]     buf_head;
  logic [CW-1:0]     wf_cnt;
  logic [HALF_W-1:0] ram_lo, ram_hi, rd_lo, rd_hi;
  logic [31:0]       rdata_q;
  logic              rvalid_q;

  assign ptr_busy_o = (wf_cnt != '0);
  assign ptr_load   = ptr_we_i && !ptr_busy_o;
  assign wr_ok      = data_wr_i && !ptr_o[PTR_RD];
  assign rd_ok      = data_rd_i &&  ptr_o[PTR_RD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pnr_q <= '0;
    else if (pnr_we_i) pnr_q <= pnr_wdata_i;
  end

  pdp_ptr u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_wdata_i),
    .step_i     (wr_ok || rd_ok),
    .wide_i     (data_wide_i),
    .ptr_o      (ptr_o)
  );

  assign pkt_sel = ptr_o[PTR_RCV] ? rx_head_i : pnr_q;
  assign widx    = ptr_o[OFF_W-1:1];
  assign widx_hi = widx + 1'b1;
  assign hi_in   = (widx != '1);   // upper half still inside the page

  pdp_wbuf #(.DEPTH(FIFO_DEPTH), .EW(EW)) u_wbuf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_lo_i (wr_ok),
    .lo_i      ({pkt_sel, widx, data_wdata_i[15:0]}),
    .push_hi_i (wr_ok && data_wide_i && hi_in),
    .hi_i      ({pkt_sel, widx_hi, data_wdata_i[31:16]}),
    .pop_o     (buf_pop),
    .head_o    (buf_head),
    .cnt_o     (wf_cnt)
  );

  pdp_ram #(.AW(AW), .DW(HALF_W)) u_ram (
    .clk_i     (clk_i),
    .we_i      (buf_pop),
    .waddr_i   (buf_head[EW-1:HALF_W]),
    .wdata_i   (buf_head[HALF_W-1:0]),
    .raddr_a_i ({pkt_sel, widx}),
    .raddr_b_i ({pkt_sel, widx_hi}),
    .rdata_a_o (ram_lo),
    .rdata_b_o (ram_hi)
  );

  assign rd_lo = view_half(ram_lo, widx == WIDX_W'(1));
  assign rd_hi = (data_wide_i && hi_in) ? view_half(ram_hi, widx_hi == WIDX_W'(1)) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      if (rd_ok) rdata_q <= {rd_hi, rd_lo};
    end
  end

  assign data_rdata_o  = rdata_q;
  assign data_rvalid_o = rvalid_q;
endmodule

// File: rtl/pkt_data_port_chk.sv
module pkt_data_port_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ptr_we_i,
  input logic          data_wr_i,
  input logic          data_rd_i,
  input logic          data_wide_i,
  input logic [15:0]   ptr_o,
  input logic          ptr_busy_o,
  input logic [31:0]   data_rdata_o,
  input logic          data_rvalid_o,
  input logic [CW-1:0] wf_cnt
);
  assert_busy_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i && ptr_busy_o |=> $stable(ptr_o));

  assert_rvalid_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rvalid_o |-> $past(data_rd_i && ptr_o[13]));

  assert_step16_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_i && ptr_o[13] && ptr_o[14] && !data_wide_i && !ptr_we_i
    |=> ptr_o[10:0] == $past(ptr_o[10:0]) + 11'd2);

  assert_no_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i || data_wr_i) && !ptr_o[14] && !ptr_we_i |=> $stable(ptr_o[10:0]));

  assert_wrong_dir_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && ptr_o[13] && !ptr_busy_o |=> !ptr_busy_o);

  assert_cnt_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rvalid_o && $past(!data_wide_i && ptr_o[10:1] == 10'd1)
    |-> data_rdata_o[31:11] == 21'd0);

  assert_busy_after_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr_i && !ptr_o[13] |=> ptr_busy_o);

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wf_cnt <= CW'(DEPTH));
endmodule

bind pkt_data_port pkt_data_port_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ptr_we_i      (ptr_we_i),
  .data_wr_i     (data_wr_i),
  .data_rd_i     (data_rd_i),
  .data_wide_i   (data_wide_i),
  .ptr_o         (ptr_o),
  .ptr_busy_o    (ptr_busy_o),
  .data_rdata_o  (data_rdata_o),
  .data_rvalid_o (data_rvalid_o),
  .wf_cnt        (wf_cnt)
);

// File: tb/pkt_data_port_test.sv
`timescale 1ns/1ps
module pkt_data_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pnr_we = 1'b0;
  logic [0:0]  pnr_wdata = '0;
  logic [0:0]  rx_head = '0;
  logic        ptr_we = 1'b0;
  logic [15:0] ptr_wdata = '0;
  logic        data_wr = 1'b0, data_rd = 1'b0, data_wide = 1'b0;
  logic [31:0] data_wdata = '0;
  logic [31:0] data_rdata;
  logic        data_rvalid;
  logic [15:0] ptr_rb;
  logic        busy;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pkt_data_port uut (
    .clk_i(clk), .rst_ni(rst_n),
    .pnr_we_i(pnr_we), .pnr_wdata_i(pnr_wdata), .rx_head_i(rx_head),
    .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata),
    .data_wr_i(data_wr), .data_rd_i(data_rd), .data_wide_i(data_wide),
    .data_wdata_i(data_wdata), .data_rdata_o(data_rdata),
    .data_rvalid_o(data_rvalid), .ptr_o(ptr_rb), .ptr_busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as the port delivers it
  always @(negedge clk) begin
    if (rst_n && data_rvalid) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        chk(tag_q.pop_front(), data_rdata, exp_q.pop_front());
      end
    end
  end

  // all tasks start on a falling edge and end on the next one
  task automatic set_ptr(input logic [15:0] v);
    ptr_we = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_we = 1'b0;
  endtask

  task automatic set_pnr(input logic [0:0] v);
    pnr_we = 1'b1; pnr_wdata = v;
    @(negedge clk); pnr_we = 1'b0;
  endtask

  task automatic wr(input logic wide, input logic [31:0] d);
    data_wr = 1'b1; data_wide = wide; data_wdata = d;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd(input logic wide, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    data_rd = 1'b1; data_wide = wide;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ptr", {16'd0, ptr_rb}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 rvalid", {31'd0, data_rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ptr after release", {16'd0, ptr_rb}, 32'd0);

    set_pnr(1'b0);
    set_ptr(16'h4000);
    chk("R2 ptr load", {16'd0, ptr_rb}, 32'h4000);
    set_ptr(16'h4800);
    chk("R2 bits 11/15 zero", {16'd0, ptr_rb}, 32'h4000);

    wr(1'b1, 32'hF840_1234);
    chk("R9 busy after wr32", {31'd0, busy}, 32'd1);
    chk("R6 step 4", {16'd0, ptr_rb}, 32'h4004);
    @(negedge clk);
    chk("R9 busy one left", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R9 busy drained", {31'd0, busy}, 32'd0);

    wr(1'b0, 32'h0000_ABCD);
    set_ptr(16'h6000);
    chk("R2 reload while busy ignored", {16'd0, ptr_rb}, 32'h4006);

    wr(1'b1, 32'h2222_1111);
    wr(1'b1, 32'h4444_3333);
    chk("R9 busy back-to-back", {31'd0, busy}, 32'd1);
    chk("R6 two steps", {16'd0, ptr_rb}, 32'h400E);
    wait_idle();

    set_ptr(16'h6000);
    rd(1'b1, 32'h0040_1234, "R5/R8 status+count");
    rd(1'b0, 32'h0000_ABCD, "R4 rd16");
    rd(1'b1, 32'h2222_1111, "R5 rd32");
    rd(1'b1, 32'h4444_3333, "R5 rd32 b");
    chk("R6 read steps", {16'd0, ptr_rb}, 32'h600E);

    set_ptr(16'h2002);
    rd(1'b0, 32'h0000_0040, "R8 count mask");
    rd(1'b0, 32'h0000_0040, "R8 count mask again");
    chk("R6 no auto-advance", {16'd0, ptr_rb}, 32'h2002);

    wr(1'b0, 32'h0000_9999);
    chk("R7 wr in read mode busy", {31'd0, busy}, 32'd0);
    chk("R7 wr in read mode ptr", {16'd0, ptr_rb}, 32'h2002);
    set_ptr(16'h2004);
    rd(1'b0, 32'h0000_ABCD, "R7 memory unchanged");

    set_ptr(16'h4000);
    data_rd = 1'b1; data_wide = 1'b0;
    @(negedge clk); data_rd = 1'b0;
    chk("R7 rd in write mode rvalid", {31'd0, data_rvalid}, 32'd0);
    chk("R7 rd in write mode ptr", {16'd0, ptr_rb}, 32'h4000);

    set_pnr(1'b1);
    wr(1'b0, 32'h0000_5555);
    wait_idle();
    set_pnr(1'b0);
    rx_head = 1'b1;
    set_ptr(16'h3000);
    rd(1'b0, 32'h0000_5555, "R3 receive head page");
    set_ptr(16'h2000);
    rd(1'b0, 32'h0000_1234, "R3 packet register page");

    set_ptr(16'h47FE);
    wr(1'b1, 32'hBEEF_CAFE);
    chk("R10 ptr wraps", {16'd0, ptr_rb}, 32'h4002);
    wait_idle();
    set_ptr(16'h67FE);
    rd(1'b1, 32'h0000_CAFE, "R10 hi half zero");
    chk("R10 read wraps", {16'd0, ptr_rb}, 32'h6002);
    set_ptr(16'h2000);
    rd(1'b0, 32'h0000_1234, "R10 page0 word0 intact");
    set_pnr(1'b1);
    rd(1'b0, 32'h0000_5555, "R10 page1 word0 intact");

    repeat (3) @(negedge clk);
    chk("queue drained", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule